// File: doc/BRIEF.md
# Starvation Escalation Reissue Timer

This block keeps the timers for a small number of outstanding DMA requests in a directory that gathers tokens by broadcast. When the directory sends its broadcast for a request, the slot for that request is armed with a long initial wait. The wait can run out before every token has arrived. When it does, the slot asks to escalate to a persistent request. The escalation goes ahead only if the persistent-request table allows it and no other persistent request from this node is active. A refused escalation re-arms the slot with a short retry wait.

A node-wide starving flag allows at most one active persistent request. When a request completes and it had escalated, the block emits a deactivate pulse and clears the flag. An expiry that happens while the slot waits on memory does not escalate. It only reloads the long wait. Token counting and message formats belong to the surrounding directory.

Top module: `starve_escalator`

## Requirements
- R1: After reset no slot is busy or armed, the starving flag is clear, and neither output pulse is high.
- R2: An arm to an idle slot makes it busy and armed, and the slot expires INIT_WAIT (default 100) cycles after the arm edge. An arm to a busy slot is ignored and changes neither its timing nor its type.
- R3: On expiry, if table_ok_i is high and starving is clear, issue_persist_o pulses for one cycle. issue_slot_o carries the slot index and issue_write_o the type (1 = write, 0 = read). The starving flag sets and the slot is disarmed, so no further request follows from that slot.
- R4: If escalation is refused at expiry, the slot re-arms and expires again RETRY_WAIT (default 10) cycles later.
- R5: Only one persistent request is active at a time. An expiry while starving is set is refused. When several slots expire in the same cycle, the lowest slot index escalates and the others are refused.
- R6: A disarm stops the slot's timer, so the slot never escalates while it stays disarmed.
- R7: A restart reloads INIT_WAIT only into an armed slot. A restart to a disarmed slot has no effect.
- R8: An expiry while the slot's mem_wait_i bit is high reloads INIT_WAIT and does not escalate.
- R9: A done frees the slot. If the slot had escalated, issue_deact_o pulses one cycle later with deact_slot_o set to the slot, and starving clears. Otherwise no deactivate is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Broadcast sent: arm slot arm_slot_i |
| arm_slot_i | input | IDX_W | Slot to arm |
| arm_write_i | input | 1 | Request type of the armed slot, 1 = write |
| disarm_i | input | 1 | All tokens or final data arrived: disarm slot |
| disarm_slot_i | input | IDX_W | Slot to disarm |
| restart_i | input | 1 | Reload the long wait if the slot is armed |
| restart_slot_i | input | IDX_W | Slot to restart |
| done_i | input | 1 | Request complete: free slot |
| done_slot_i | input | IDX_W | Slot to free |
| mem_wait_i | input | NSLOT | Per slot: waiting on memory |
| table_ok_i | input | 1 | Persistent table permits issue |
| issue_persist_o | output | 1 | One-cycle persistent request pulse |
| issue_slot_o | output | IDX_W | Slot that escalated |
| issue_write_o | output | 1 | Type of the escalation, 1 = write |
| issue_deact_o | output | 1 | One-cycle deactivate pulse |
| deact_slot_o | output | IDX_W | Slot being deactivated |
| starving_o | output | 1 | Node-wide starving flag |
| busy_o | output | NSLOT | Slot holds a request |
| armed_o | output | NSLOT | Slot timer running |

## Verification
A slot armed at edge E acts at edge E+INIT_WAIT. A refusal or a restart at edge X moves the next action to X+RETRY_WAIT or X+INIT_WAIT. The issue pulse is visible in the cycle after the acting edge. A done at edge D shows the deactivate pulse after D. The bench drives inputs on falling edges and counts edges from the arm. It samples on falling edges one cycle before and exactly at each due edge, so that an early or late pulse is caught. Windows where nothing may be issued are scanned every cycle.

// File: rtl/starve_pkg.sv
package starve_pkg;
  // counter reload selection of one slot
  typedef enum logic [1:0] {
    LD_HOLD  = 2'd0,
    LD_LONG  = 2'd1,
    LD_SHORT = 2'd2,
    LD_DEC   = 2'd3
  } load_sel_e;
endpackage

// File: rtl/starve_slot.sv
module starve_slot
  import starve_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int INIT_WAIT  = 100,
  parameter int RETRY_WAIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic arm_write,
  input  logic disarm,
  input  logic restart,
  input  logic done,
  input  logic mem_wait,
  input  logic grant,
  output logic expire,
  output logic esc_req,
  output logic armed,
  output logic busy,
  output logic is_write,
  output logic went
);
  logic [CNT_W-1:0] cnt_q;
  load_sel_e        ld_sel;

  function automatic logic [CNT_W-1:0] next_cnt(load_sel_e s, logic [CNT_W-1:0] c);
    case (s)
      LD_LONG:  return CNT_W'(INIT_WAIT);
      LD_SHORT: return CNT_W'(RETRY_WAIT);
      LD_DEC:   return c - CNT_W'(1);
      default:  return c;
    endcase
  endfunction

  assign expire  = busy && armed && (cnt_q == CNT_W'(1));
  assign esc_req = expire && !mem_wait;

  always_comb begin
    ld_sel = LD_HOLD;
    if (done && busy)                 ld_sel = LD_HOLD;
    else if (arm && !busy)            ld_sel = LD_LONG;
    else if (busy && !disarm) begin
      if (expire) begin
        if (mem_wait)                 ld_sel = LD_LONG;
        else if (!grant)              ld_sel = LD_SHORT;
      end
      else if (restart && armed)      ld_sel = LD_LONG;
      else if (armed)                 ld_sel = LD_DEC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      armed    <= 1'b0;
      busy     <= 1'b0;
      is_write <= 1'b0;
      went     <= 1'b0;
    end else begin
      cnt_q <= next_cnt(ld_sel, cnt_q);
      if (done && busy) begin
        busy  <= 1'b0;
        armed <= 1'b0;
        went  <= 1'b0;
      end else if (arm && !busy) begin
        busy     <= 1'b1;
        armed    <= 1'b1;
        is_write <= arm_write;
        went     <= 1'b0;
      end else if (busy) begin
        if (disarm) armed <= 1'b0;
        else if (expire && !mem_wait && grant) begin
          armed <= 1'b0;
          went  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/starve_arbiter.sv
module starve_arbiter #(
  parameter int NSLOT = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] req,
  input  logic             table_ok,
  input  logic             deact_req,
  output logic [NSLOT-1:0] grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             starving
);
  function automatic logic [NSLOT-1:0] lowest_one(logic [NSLOT-1:0] v);
    return v & (~v + NSLOT'(1));
  endfunction

  function automatic logic [IDX_W-1:0] index_of(logic [NSLOT-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSLOT; i++)
      if (oh[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign grant     = (table_ok && !starving) ? lowest_one(req) : '0;
  assign grant_idx = index_of(grant);

  always_ff @(posedge clk) begin
    if (!rst_n)          starving <= 1'b0;
    else if (|grant)     starving <= 1'b1;
    else if (deact_req)  starving <= 1'b0;
  end
endmodule

// File: rtl/starve_escalator.sv
module starve_escalator #(
  parameter int NSLOT      = 2,
  parameter int CNT_W      = 16,
  parameter int INIT_WAIT  = 100,
  parameter int RETRY_WAIT = 10,
  localparam int IDX_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [IDX_W-1:0] arm_slot_i,
  input  logic             arm_write_i,
  input  logic             disarm_i,
  input  logic [IDX_W-1:0] disarm_slot_i,
  input  logic             restart_i,
  input  logic [IDX_W-1:0] restart_slot_i,
  input  logic             done_i,
  input  logic [IDX_W-1:0] done_slot_i,
  input  logic [NSLOT-1:0] mem_wait_i,
  input  logic             table_ok_i,
  output logic             issue_persist_o,
  output logic [IDX_W-1:0] issue_slot_o,
  output logic             issue_write_o,
  output logic             issue_deact_o,
  output logic [IDX_W-1:0] deact_slot_o,
  output logic             starving_o,
  output logic [NSLOT-1:0] busy_o,
  output logic [NSLOT-1:0] armed_o
);
  logic [NSLOT-1:0] arm_v, disarm_v, restart_v, done_v;
  logic [NSLOT-1:0] expire_v, esc_req_v, grant_v, write_v, went_v;
  logic [IDX_W-1:0] grant_idx;
  logic             deact_req;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      assign arm_v[g]     = arm_i     && (arm_slot_i     == IDX_W'(g));
      assign disarm_v[g]  = disarm_i  && (disarm_slot_i  == IDX_W'(g));
      assign restart_v[g] = restart_i && (restart_slot_i == IDX_W'(g));
      assign done_v[g]    = done_i    && (done_slot_i    == IDX_W'(g));

      starve_slot #(
        .CNT_W(CNT_W), .INIT_WAIT(INIT_WAIT), .RETRY_WAIT(RETRY_WAIT)
      ) u_slot (
        .clk(clk), .rst_n(rst_n),
        .arm(arm_v[g]), .arm_write(arm_write_i),
        .disarm(disarm_v[g]), .restart(restart_v[g]), .done(done_v[g]),
        .mem_wait(mem_wait_i[g]), .grant(grant_v[g]),
        .expire(expire_v[g]), .esc_req(esc_req_v[g]),
        .armed(armed_o[g]), .busy(busy_o[g]),
        .is_write(write_v[g]), .went(went_v[g])
      );
    end
  endgenerate

  assign deact_req = |(done_v & busy_o & went_v);

  starve_arbiter #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(esc_req_v), .table_ok(table_ok_i), .deact_req(deact_req),
    .grant(grant_v), .grant_idx(grant_idx), .starving(starving_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_persist_o <= 1'b0;
      issue_slot_o    <= '0;
      issue_write_o   <= 1'b0;
      issue_deact_o   <= 1'b0;
      deact_slot_o    <= '0;
    end else begin
      issue_persist_o <= |grant_v;
      issue_deact_o   <= deact_req;
      if (|grant_v) begin
        issue_slot_o  <= grant_idx;
        issue_write_o <= write_v[grant_idx];
      end
      if (deact_req) deact_slot_o <= done_slot_i;
    end
  end
endmodule

// File: rtl/starve_escalator_chk.sv
module starve_escalator_chk #(
  parameter int NSLOT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_persist_o,
  input logic             issue_deact_o,
  input logic             starving_o,
  input logic [NSLOT-1:0] busy_o,
  input logic [NSLOT-1:0] armed_o,
  input logic [NSLOT-1:0] grant_v,
  input logic [NSLOT-1:0] expire_v
);
  p_armed_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o & ~busy_o) == '0);
  p_issue_starve_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_persist_o |-> starving_o);
  p_issue_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_persist_o |-> !$past(starving_o));
  p_grant_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_v));
  p_grant_expired_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_v & ~expire_v) == '0);
  p_deact_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_deact_o |-> (!starving_o && $past(starving_o)));
  p_no_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_persist_o && issue_deact_o));
endmodule

bind starve_escalator starve_escalator_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .issue_persist_o(issue_persist_o), .issue_deact_o(issue_deact_o),
  .starving_o(starving_o), .busy_o(busy_o), .armed_o(armed_o),
  .grant_v(grant_v), .expire_v(expire_v)
);

// File: tb/starve_escalator_test.sv
`timescale 1ns/1ps
module starve_escalator_test;
  localparam int LW = 100;
  localparam int SW = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic arm_i = 0, arm_write_i = 0, disarm_i = 0, restart_i = 0, done_i = 0;
  logic [0:0] arm_slot_i = 0, disarm_slot_i = 0, restart_slot_i = 0, done_slot_i = 0;
  logic [1:0] mem_wait_i = 0;
  logic table_ok_i = 0;
  logic issue_persist_o, issue_write_o, issue_deact_o, starving_o;
  logic [0:0] issue_slot_o, deact_slot_o;
  logic [1:0] busy_o, armed_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  starve_escalator #(.NSLOT(2), .CNT_W(16), .INIT_WAIT(LW), .RETRY_WAIT(SW)) uut (
    .clk(clk), .rst_n(rst_n),
    .arm_i(arm_i), .arm_slot_i(arm_slot_i), .arm_write_i(arm_write_i),
    .disarm_i(disarm_i), .disarm_slot_i(disarm_slot_i),
    .restart_i(restart_i), .restart_slot_i(restart_slot_i),
    .done_i(done_i), .done_slot_i(done_slot_i),
    .mem_wait_i(mem_wait_i), .table_ok_i(table_ok_i),
    .issue_persist_o(issue_persist_o), .issue_slot_o(issue_slot_o),
    .issue_write_o(issue_write_o), .issue_deact_o(issue_deact_o),
    .deact_slot_o(deact_slot_o), .starving_o(starving_o),
    .busy_o(busy_o), .armed_o(armed_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // arm a slot; returns after the arm edge (t0)
  task automatic do_arm(input int slot, input bit wr);
    arm_i = 1; arm_slot_i = 1'(slot); arm_write_i = wr;
    tick(1);
    arm_i = 0;
  endtask

  // complete a slot; returns after the done edge
  task automatic do_done(input int slot);
    done_i = 1; done_slot_i = 1'(slot);
    tick(1);
    done_i = 0;
  endtask

  task automatic count_issue(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (issue_persist_o) c++;
    end
  endtask

  initial begin
    int c;
    tick(3);
    // R1 reset state
    eq("R1 busy", busy_o, 0);
    eq("R1 armed", armed_o, 0);
    eq("R1 starving", starving_o, 0);
    eq("R1 pulses", {issue_persist_o, issue_deact_o}, 0);
    rst_n = 1;
    tick(1);

    // A: escalation after the long wait (R2 R3), then completion (R9)
    table_ok_i = 1;
    do_arm(0, 1);
    eq("R2 busy after arm", busy_o[0], 1);
    eq("R2 armed after arm", armed_o[0], 1);
    tick(LW - 1);
    eq("R2 no early issue", issue_persist_o, 0);
    tick(1);
    eq("R3 issue at long wait", issue_persist_o, 1);
    eq("R3 issue slot", issue_slot_o, 0);
    eq("R3 issue write", issue_write_o, 1);
    eq("R3 starving set", starving_o, 1);
    eq("R3 slot disarmed", armed_o[0], 0);
    count_issue(150, c);
    eq("R3 no reissue", c, 0);
    do_done(0);
    eq("R9 deact pulse", issue_deact_o, 1);
    eq("R9 deact slot", deact_slot_o, 0);
    eq("R9 starving cleared", starving_o, 0);
    eq("R9 slot freed", busy_o[0], 0);
    tick(1);
    eq("R9 deact one cycle", issue_deact_o, 0);

    // B: refused then retry after short wait (R4)
    table_ok_i = 0;
    do_arm(1, 0);
    tick(LW);
    eq("R4 refused no issue", issue_persist_o, 0);
    eq("R4 still armed", armed_o[1], 1);
    table_ok_i = 1;
    tick(SW - 1);
    eq("R4 no early retry", issue_persist_o, 0);
    tick(1);
    eq("R4 retry issue", issue_persist_o, 1);
    eq("R4 retry slot", issue_slot_o, 1);
    eq("R4 read type", issue_write_o, 0);
    do_done(1);
    eq("R9 deact slot 1", {issue_deact_o, deact_slot_o}, 3);

    // C: starving blocks a second slot (R5)
    do_arm(0, 1);
    do_arm(1, 0);                 // now at t1
    tick(LW - 1);                 // t100
    eq("R5 first escalates", {issue_persist_o, issue_slot_o}, 2);
    tick(1);                      // t101
    eq("R5 second refused", issue_persist_o, 0);
    tick(SW);                     // t111
    eq("R5 retry refused while starving", issue_persist_o, 0);
    do_done(0);                   // t112
    eq("R9 deact frees starving", {issue_deact_o, starving_o}, 2);
    tick(SW - 2);                 // t120
    eq("R5 no early", issue_persist_o, 0);
    tick(1);                      // t121
    eq("R5 second escalates later", {issue_persist_o, issue_slot_o}, 3);
    do_done(1);

    // D: simultaneous expiry, lowest index wins; restart of armed slot (R5 R7)
    do_arm(1, 1);                 // t0
    arm_i = 1; arm_slot_i = 0; arm_write_i = 0;
    restart_i = 1; restart_slot_i = 1;
    tick(1);                      // t1
    arm_i = 0; restart_i = 0;
    tick(LW - 1);                 // t100
    eq("R7 restarted slot waits", issue_persist_o, 0);
    tick(1);                      // t101
    eq("R5 lowest wins", {issue_persist_o, issue_slot_o}, 2);
    eq("R5 loser still armed", armed_o[1], 1);
    tick(SW);
    eq("R5 loser refused", issue_persist_o, 0);
    do_done(0);
    do_done(1);
    eq("R9 non-escalated done no deact", issue_deact_o, 0);
    eq("R9 both free", busy_o, 0);

    // E: disarm and restart of disarmed slot (R6 R7 R9)
    do_arm(0, 1);
    tick(49);
    disarm_i = 1; disarm_slot_i = 0;
    tick(1);
    disarm_i = 0;
    eq("R6 disarmed", {busy_o[0], armed_o[0]}, 2);
    restart_i = 1; restart_slot_i = 0;
    tick(1);
    restart_i = 0;
    eq("R7 restart no rearm", armed_o[0], 0);
    count_issue(200, c);
    eq("R6 no issue after disarm", c, 0);
    do_done(0);
    eq("R9 no deact without escalation", issue_deact_o, 0);

    // F: expiry while waiting on memory (R8)
    mem_wait_i = 2'b01;
    do_arm(0, 0);
    tick(LW);
    eq("R8 no issue on mem wait", issue_persist_o, 0);
    eq("R8 still armed", armed_o[0], 1);
    mem_wait_i = 0;
    tick(LW - 1);
    eq("R8 no early", issue_persist_o, 0);
    tick(1);
    eq("R8 issue after reload", issue_persist_o, 1);
    do_done(0);

    // G: arm to a busy slot ignored (R2)
    do_arm(1, 0);
    tick(40);
    do_arm(1, 1);                 // t41
    tick(LW - 42);                // t99
    eq("R2 no early after ignored arm", issue_persist_o, 0);
    tick(1);                      // t100
    eq("R2 timing kept", issue_persist_o, 1);
    eq("R2 type kept", issue_write_o, 0);
    do_done(1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule